// File: doc/BRIEF.md
# Wake-Up Real-Time Counter

This block keeps elapsed time in a 40-bit counter that advances once per 128 cycles of its clock, so a 32.768 kHz source yields 256 counts per second. A 40-bit compare value sits beside the counter. A single-bit output is high whenever the two are equal, and a power-domain controller can use it as a wake-up request.

Software reaches both 40-bit values and a small control byte through an 8-bit register port with a 4-bit offset. Each 40-bit value is exposed as five bytes, least significant byte at the lowest offset. Counting can be paused and resumed. An optional auto-clear mode turns the counter into a periodic timer: when the count equals the compare value, the next advance returns it to zero. A count of zero is never cleared this way, so a zero compare value cannot freeze the timer.

Top module: `rtc_core`

## Requirements
- R1: After reset the counter and the compare value are zero, the control byte reads 0x04, and `hit_o` is 1.
- R2: A read of offset `addr` asserted with `rd_en` at one clock edge returns that register's value on `rdata` after the same edge. Offsets 0..4 hold counter bytes 0..4 and offsets 5..9 hold compare bytes 0..4, least significant byte first.
- R3: Each of the ten counter and compare bytes can be written independently and reads back the written value.
- R4: Counting requires the control bit 0 (run). While run is set, the counter increases by one every 128 clocks, and the first increase comes 64 clocks after the prescaler was last cleared. While run is clear, the counter holds its value.
- R5: `hit_o` is 1 exactly when the full 40-bit counter equals the full 40-bit compare value.
- R6: With control bit 1 (auto-clear) set, an advance taken while the counter equals a nonzero compare value loads zero. With the bit clear, the counter just steps past the compare value.
- R7: An advance from a count of zero always gives one, even when auto-clear is set and the compare value is zero.
- R8: Without auto-clear, the counter wraps from 0xFFFFFFFFFF to zero, and carries propagate across all five bytes.
- R9: A write to a counter byte on the same edge as an advance wins: the written byte is stored, no increment is applied, and the prescaler restarts from zero.
- R10: Control bit 2 reads as the current `hit_o` and ignores writes. Bits 7..3 of the control byte read as zero.
- R11: Offsets 11..15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock, divided by 128 for counting |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe; data appears one edge later |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| hit_o | output | 1 | High while counter equals compare value |

## Verification
The hardest case to reach is an advance that lands on the same edge as a counter-byte write, because the advance edge depends on hidden prescaler state. The stimulus first clears the prescaler with a counter write while counting is paused. Every later edge is then counted exactly from the write that sets run, so the bench can schedule a write onto the 64th edge. It then times reads onto the edges just before and after the following advance. The same deterministic timing takes the counter through auto-clear at a nonzero compare value, through the zero exception, and through a full 40-bit wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CNT_W   = 40;
    localparam int BYTE_W  = 8;
    localparam int PRE_W   = 7;
    localparam int ADDR_W  = 4;
    localparam int NBYTES  = CNT_W / BYTE_W;
    localparam int IDX_W   = $clog2(NBYTES);
    localparam int CTRL_OFS = 2 * NBYTES;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_CMP,
        SEL_CTRL
    } sel_e;

    typedef struct packed {
        sel_e             kind;
        logic [IDX_W-1:0] idx;
    } addr_dec_t;

    typedef struct packed {
        logic autoclr;
        logic run;
    } ctrl_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.kind = SEL_NONE;
        d.idx  = '0;
        if (a < ADDR_W'(NBYTES)) begin
            d.kind = SEL_CNT;
            d.idx  = IDX_W'(a);
        end else if (a < ADDR_W'(2 * NBYTES)) begin
            d.kind = SEL_CMP;
            d.idx  = IDX_W'(a - ADDR_W'(NBYTES));
        end else if (a == ADDR_W'(CTRL_OFS)) begin
            d.kind = SEL_CTRL;
        end
        return d;
    endfunction

    function automatic logic [CNT_W-1:0] next_count(
        input logic [CNT_W-1:0] cur,
        input logic [CNT_W-1:0] cmp,
        input logic             autoclr
    );
        if (autoclr && (cur == cmp) && (cur != '0))
            return '0;
        return cur + CNT_W'(1);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam logic [W-1:0] RISE_AT = W'((1 << (W - 1)) - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            div_q <= '0;
        else if (run)
            div_q <= div_q + W'(1);
    end

    // divided clock is div_q[W-1]; its rising edge happens when div_q leaves RISE_AT
    assign tick = run && !restart && (div_q == RISE_AT);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             autoclr,
    input  logic [NB*BW-1:0] cmp_val,
    input  logic [NB-1:0]    wr_sel,
    input  logic [BW-1:0]    wdata,
    output logic [NB*BW-1:0] cnt
);
    logic [NB*BW-1:0] cnt_q;
    logic [NB*BW-1:0] adv;
    logic [NB*BW-1:0] base;

    always_comb begin
        adv  = next_count(cnt_q, cmp_val, autoclr);
        base = tick ? adv : cnt_q;
    end

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q[i*BW +: BW] <= '0;
            else if (wr_sel[i])
                cnt_q[i*BW +: BW] <= wdata;
            else
                cnt_q[i*BW +: BW] <= base[i*BW +: BW];
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int NB = NBYTES,
    parameter int BW = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  addr_dec_t        dec,
    input  logic [BW-1:0]    wdata,
    input  logic [NB*BW-1:0] cnt,
    input  logic             hit,
    output logic [NB*BW-1:0] cmp_val,
    output ctrl_t            ctrl,
    output logic [BW-1:0]    rdata
);
    logic [NB*BW-1:0] cmp_q;
    ctrl_t            ctrl_q;
    logic [BW-1:0]    rd_mux;
    logic [BW-1:0]    rdata_q;

    for (genvar i = 0; i < NB; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[i*BW +: BW] <= '0;
            else if (wr_en && dec.kind == SEL_CMP && dec.idx == IDX_W'(i))
                cmp_q[i*BW +: BW] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && dec.kind == SEL_CTRL)
            ctrl_q <= '{autoclr: wdata[1], run: wdata[0]};
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.kind)
            SEL_CNT: begin
                for (int i = 0; i < NB; i++)
                    if (dec.idx == IDX_W'(i))
                        rd_mux = cnt[i*BW +: BW];
            end
            SEL_CMP: begin
                for (int i = 0; i < NB; i++)
                    if (dec.idx == IDX_W'(i))
                        rd_mux = cmp_q[i*BW +: BW];
            end
            SEL_CTRL: begin
                rd_mux[0] = ctrl_q.run;
                rd_mux[1] = ctrl_q.autoclr;
                rd_mux[2] = hit;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign cmp_val = cmp_q;
    assign ctrl    = ctrl_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              hit_o
);
    addr_dec_t          dec;
    logic [NBYTES-1:0]  cnt_wr_sel;
    logic               cnt_wr_any;
    logic               tick;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cmp_q;
    ctrl_t              ctrl_q;
    logic               ctrl_run;
    logic               ctrl_clr;

    assign dec = decode_addr(addr);

    for (genvar i = 0; i < NBYTES; i++) begin : g_wsel
        assign cnt_wr_sel[i] = wr_en && dec.kind == SEL_CNT && dec.idx == IDX_W'(i);
    end
    assign cnt_wr_any = |cnt_wr_sel;

    assign ctrl_run = ctrl_q.run;
    assign ctrl_clr = ctrl_q.autoclr;

    rtc_prescaler #(.W(PRE_W)) pre_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_run),
        .restart (cnt_wr_any),
        .tick    (tick)
    );

    rtc_counter #(.NB(NBYTES), .BW(BYTE_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .autoclr (ctrl_clr),
        .cmp_val (cmp_q),
        .wr_sel  (cnt_wr_sel),
        .wdata   (wdata),
        .cnt     (cnt_q)
    );

    assign hit_o = (cnt_q == cmp_q);

    rtc_regs #(.NB(NBYTES), .BW(BYTE_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .dec     (dec),
        .wdata   (wdata),
        .cnt     (cnt_q),
        .hit     (hit_o),
        .cmp_val (cmp_q),
        .ctrl    (ctrl_q),
        .rdata   (rdata)
    );

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata,
    input logic [BYTE_W-1:0] rdata,
    input logic              hit_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              run,
    input logic              clr,
    input logic              tick
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr < ADDR_W'(NBYTES));

    AST_HIT_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> hit_o); // R1

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) tick |-> run); // R4

    AST_PAUSED_HOLDS: assert property (@(posedge clk) disable iff (rst) (!run && !cnt_wr) |=> (cnt == $past(cnt))); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst) (tick && !(clr && cnt == cmp && cnt != '0)) |=> (cnt == $past(cnt) + CNT_W'(1))); // R8

    AST_AUTOCLR_ZERO: assert property (@(posedge clk) disable iff (rst) (tick && clr && cnt == cmp && cnt != '0) |=> (cnt == '0)); // R6

    AST_ZERO_ADVANCES: assert property (@(posedge clk) disable iff (rst) (tick && cnt == '0) |=> (cnt == CNT_W'(1))); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) (wr_en && addr == '0) |=> (cnt[BYTE_W-1:0] == $past(wdata))); // R9

    AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && addr == ADDR_W'(CTRL_OFS)) |=> (rdata[BYTE_W-1:3] == '0)); // R10

endmodule

bind rtc_core rtc_core_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .hit_o (hit_o),
    .cnt   (cnt_q),
    .cmp   (cmp_q),
    .run   (ctrl_run),
    .clr   (ctrl_clr),
    .tick  (tick)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       hit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    logic  rd_seen = 1'b0;

    always #2 clk = ~clk;

    rtc_core dut_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .hit_o (hit_o)
    );

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: pops expected read data once the registered read has returned
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s rdata=%02h expected=%02h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1;
        addr  = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_hit(input logic e, input string tag);
        checks++;
        if (hit_o !== e) begin
            errors++;
            $display("FAIL %s hit_o=%0b expected=%0b", tag, hit_o, e);
        end
    endtask

    task automatic load_cnt(input logic [39:0] v);
        for (int i = 0; i < 5; i++) wr(4'(i), v[i*8 +: 8]);
    endtask

    task automatic load_cmp(input logic [39:0] v);
        for (int i = 0; i < 5; i++) wr(4'(5 + i), v[i*8 +: 8]);
    endtask

    task automatic rd_cnt(input logic [39:0] v, input string tag);
        for (int i = 0; i < 5; i++) rd(4'(i), v[i*8 +: 8], tag);
    endtask

    // write byte 0 (clears prescaler), run for exactly n advances, then pause
    task automatic run_ticks(input logic [7:0] b0, input int n, input logic clr);
        wr(4'd0, b0);
        wr(4'd10, {6'b0, clr, 1'b1});
        repeat (64 + 128 * (n - 1) + 9) @(negedge clk);
        wr(4'd10, {6'b0, clr, 1'b0});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_hit(1'b1, "R1 hit after reset");
        for (int i = 0; i < 10; i++) rd(4'(i), 8'h00, "R1 zero after reset");
        rd(4'd10, 8'h04, "R1 ctrl after reset");

        // R3 / R2 byte write and readback
        load_cnt(40'h55_44_33_22_11);
        load_cmp(40'hA5_A4_A3_A2_A1);
        rd_cnt(40'h55_44_33_22_11, "R3 counter bytes");
        for (int i = 0; i < 5; i++) rd(4'(5 + i), 8'hA1 + 8'(i), "R2 compare byte order");
        chk_hit(1'b0, "R5 differ");

        // R11 unmapped offsets
        for (int i = 11; i < 16; i++) wr(4'(i), 8'hFF);
        for (int i = 11; i < 16; i++) rd(4'(i), 8'h00, "R11 unmapped read");
        rd(4'd0, 8'h11, "R11 counter untouched");
        rd(4'd9, 8'hA5, "R11 compare untouched");
        rd(4'd10, 8'h00, "R11 ctrl untouched");

        // R10 read-only hit bit
        wr(4'd10, 8'hFE);
        rd(4'd10, 8'h02, "R10 ro bit and high bits");
        wr(4'd10, 8'h00);

        // R4 exact advance timing and pause hold
        load_cnt(40'h00_00_00_00_FE);
        wr(4'd10, 8'h01);
        repeat (63) @(negedge clk);
        rd(4'd0, 8'hFE, "R4 before first advance");
        rd(4'd0, 8'hFF, "R4 after first advance");
        wr(4'd10, 8'h00);
        repeat (300) @(negedge clk);
        rd(4'd0, 8'hFF, "R4 paused holds");

        // R8 full wrap with carry
        load_cnt(40'hFF_FF_FF_FF_FF);
        load_cmp(40'h00_00_00_00_01);
        run_ticks(8'hFF, 1, 1'b0);
        rd_cnt(40'h0, "R8 wrap to zero");
        chk_hit(1'b0, "R5 zero vs one");
        run_ticks(8'h00, 1, 1'b0);
        chk_hit(1'b1, "R5 equal");
        rd(4'd10, 8'h04, "R10 hit reflected");

        // R6 auto-clear at nonzero compare value, 40-bit compare
        load_cnt(40'h01_00_00_00_00);
        load_cmp(40'h01_00_00_00_05);
        run_ticks(8'h03, 2, 1'b1);
        chk_hit(1'b1, "R6 reached compare");
        rd(4'd10, 8'h06, "R6 ctrl readback");
        run_ticks(8'h05, 1, 1'b1);
        rd_cnt(40'h0, "R6 auto-clear");
        wr(4'd4, 8'h01);
        run_ticks(8'h05, 1, 1'b0);
        rd_cnt(40'h01_00_00_00_06, "R6 disabled steps past");

        // R7 zero exception
        load_cmp(40'h0);
        load_cnt(40'h0);
        chk_hit(1'b1, "R7 zero equal");
        run_ticks(8'h00, 1, 1'b1);
        rd_cnt(40'h01, "R7 zero advances");
        chk_hit(1'b0, "R7 left zero");

        // R9 write on the advance edge
        wr(4'd0, 8'h10);
        wr(4'd10, 8'h01);
        repeat (63) @(negedge clk);
        wr(4'd0, 8'h40);
        repeat (63) @(negedge clk);
        rd(4'd0, 8'h40, "R9 write won, no increment");
        rd(4'd0, 8'h41, "R9 prescaler restarted");
        wr(4'd10, 8'h00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule